// File: doc/BRIEF.md
# Master Video Sync and Timing Generator

This block produces the complete set of timing signals that a digital composite video encoder needs when it runs as the timing master at a 13.5 MHz sample rate. A sample counter and a line counter step through each line and each frame of either 525/625-line standard. The block can run interlaced, with two fields per frame offset by half a line, or non-interlaced, with every field identical. From those counters it decodes horizontal and vertical sync, composite blanking and the colour burst window. It also produces a per-sample level code that the downstream luminance path turns into sync tip, blanking or picture. The level code includes the half-line equalizing pulses and the broad, serrated vertical sync pulses.

The standard select and the scan select are sampled only at frame boundaries, so a change never produces a torn frame. A three-bit field counter runs through the eight-field colour sequence in interlaced operation. Its low bit is the field parity. The PAL burst-blanking window depends on its two low bits. All outputs come from registers.

The field length in lines is a parameter, 262 for the 525-line standard and 312 for the 625-line standard by default. Frame and field sizes follow from it.

Top module: `vidSyncGen`

## Requirements
- R1: A line is 858 samples when `palSel` was latched as 0 (525-line mode) and 864 samples when latched as 1 (625-line mode). A half line is 429 or 432 samples. `lineNum` is the 1-based line number within the frame.
- R2: `hSyncN` is low for exactly the first 63 samples of every line, in both standards.
- R3: `syncLevel` encodes 0 = sync tip, 1 = blanking, 2 = active; 3 never appears. `blankOut` is high for samples below 127 (525) or 142 (625), for samples from 838 (525) or 844 (625) to the end of the line, and over every half line of vertical blanking. Outside blanking the level is active.
- R4: `burstGate` is high for 31 samples starting at sample 71 (525) or 75 (625), unless the current half line is burst-suppressed.
- R5: Within a field, half lines are numbered from 0 at the start of vertical sync. Sync half lines are 0..5 (525) or 0..4 (625), and each carries a broad tip of 365 (525) or 369 (625) samples with `vSyncN` low. The post-sync equalizing half lines run up to index 12 (525 interlaced) or 10 (otherwise). The pre-sync equalizing half lines are the last 6 (525 interlaced), 5 (625 interlaced) or 4 (non-interlaced) of the field. Each equalizing half line carries a tip of 31 (525) or 32 (625) samples. Outside the vertical interval the tip is the horizontal sync.
- R6: Vertical blanking covers field half lines 0..33 (525) or 0..44 (625) plus the pre-sync equalizing half lines.
- R7: With `progSel` latched as 1, a frame is one field of F lines (F = field-length parameter), that is 2F half lines. Interlaced, a frame is 2F+1 lines and the second field begins at the middle of line F+1.
- R8: In 525-line mode, burst is suppressed on field half lines 0..11 and on the pre-sync equalizing half lines. In 625-line mode, suppression covers the half lines below E and the last P half lines of the field. E and P are picked by `fieldNum[1:0]`: 0 gives E=12, P=6; 1 gives E=11, P=9; 2 gives E=10, P=5; 3 gives E=13, P=7.
- R9: `fieldNum` advances by one (mod 8) at the start of every field when interlaced and holds its value when non-interlaced. It changes only where `vSyncN` falls.
- R10: `palSel` and `progSel` are sampled while `rstN` is low and at the last sample of each frame, and at no other time.
- R11: While reset is held, the outputs are `hSyncN`=1, `vSyncN`=1, `blankOut`=1, `burstGate`=0, `syncLevel`=1, `fieldNum`=0, `lineNum`=1. After the first rising edge with `rstN` high, the outputs describe sample 0 of line 1, and every later edge advances one sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Synchronous reset, active low |
| palSel | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| progSel | input | 1 | Scan select: 0 = interlaced, 1 = non-interlaced |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync interval, active low |
| blankOut | output | 1 | Composite blanking flag |
| burstGate | output | 1 | Colour burst window |
| syncLevel | output | 2 | Per-sample level code: 0 tip, 1 blank, 2 active |
| fieldNum | output | 3 | Field sequence counter; bit 0 is parity |
| lineNum | output | 11 | Line number within the frame, from 1 |

## Verification
The assertions check the relations between outputs on every cycle:
- a tip or a vertical sync always falls inside blanking;
- an active sample never coincides with any sync or blanking;
- the burst window lies inside horizontal blanking after the sync pulse;
- `hSyncN` stays low for exactly 63 samples;
- the line number changes only at a horizontal sync edge and the field number only at a vertical sync edge.

The exact sample positions of pulse edges, blanking edges and burst edges can be shown only by the bench scenarios. The same holds for the half-line placement of sync and equalizing pulses in each field, the field-dependent burst suppression, and the frame-boundary latching of the mode inputs. The bench runs with short fields so that several frames of different modes fit in one run.

// File: rtl/vidSyncPkg.sv
package vidSyncPkg;

  localparam int CNT_W   = 11;
  localparam int FIELD_W = 3;

  typedef enum logic [1:0] {
    LVL_TIP    = 2'd0,
    LVL_BLANK  = 2'd1,
    LVL_ACTIVE = 2'd2
  } syncLvlT;

  // Per-standard horizontal and vertical constants, all in samples or half lines.
  typedef struct packed {
    logic [CNT_W-1:0] lineLen;
    logic [CNT_W-1:0] halfLen;
    logic [CNT_W-1:0] hsWidth;
    logic [CNT_W-1:0] eqWidth;
    logic [CNT_W-1:0] broadWidth;
    logic [CNT_W-1:0] burstStart;
    logic [CNT_W-1:0] burstLen;
    logic [CNT_W-1:0] hbEnd;
    logic [CNT_W-1:0] fpStart;
    logic [CNT_W-1:0] vsHalves;
    logic [CNT_W-1:0] postEnd;
    logic [CNT_W-1:0] preHalves;
    logic [CNT_W-1:0] vbEnd;
  } stdTimingT;

  // Strobes from the counter control to the decode datapath.
  typedef struct packed {
    logic               pal;
    logic               prog;
    logic [CNT_W-1:0]   sampleCnt;
    logic [CNT_W-1:0]   halfPos;
    logic [CNT_W-1:0]   fieldPos;
    logic [CNT_W-1:0]   fieldHalves;
    logic [CNT_W-1:0]   lineCnt;
    logic [FIELD_W-1:0] fieldCnt;
  } tickT;

  localparam logic [CNT_W-1:0] NTSC_BURST_END = 11'd12;

  function automatic stdTimingT stdTiming(input logic pal, input logic prog);
    stdTimingT t;
    t.lineLen    = pal ? 11'd864 : 11'd858;
    t.halfLen    = pal ? 11'd432 : 11'd429;
    t.hsWidth    = 11'd63;
    t.eqWidth    = pal ? 11'd32  : 11'd31;
    t.broadWidth = pal ? 11'd369 : 11'd365;
    t.burstStart = pal ? 11'd75  : 11'd71;
    t.burstLen   = 11'd31;
    t.hbEnd      = pal ? 11'd142 : 11'd127;
    t.fpStart    = pal ? 11'd844 : 11'd838;
    t.vsHalves   = pal ? 11'd5   : 11'd6;
    t.postEnd    = (pal || prog) ? 11'd10 : 11'd12;
    t.preHalves  = prog ? 11'd4 : (pal ? 11'd5 : 11'd6);
    t.vbEnd      = pal ? 11'd45  : 11'd34;
    return t;
  endfunction

  // 625-line burst suppression: leading half lines, indexed by field sequence.
  function automatic logic [CNT_W-1:0] palBurstEnd(input logic [1:0] seq);
    case (seq)
      2'd0:    return 11'd12;
      2'd1:    return 11'd11;
      2'd2:    return 11'd10;
      default: return 11'd13;
    endcase
  endfunction

  // 625-line burst suppression: trailing half lines, indexed by field sequence.
  function automatic logic [CNT_W-1:0] palBurstPre(input logic [1:0] seq);
    case (seq)
      2'd0:    return 11'd6;
      2'd1:    return 11'd9;
      2'd2:    return 11'd5;
      default: return 11'd7;
    endcase
  endfunction

endpackage

// File: rtl/vidSyncCtrl.sv
module vidSyncCtrl
  import vidSyncPkg::*;
#(
  parameter int NTSC_FIELD_LINES = 262,
  parameter int PAL_FIELD_LINES  = 312
) (
  input  logic clk,
  input  logic rstN,
  input  logic palSel,
  input  logic progSel,
  output tickT tick
);

  localparam logic [CNT_W-1:0] NTSC_F = CNT_W'(NTSC_FIELD_LINES);
  localparam logic [CNT_W-1:0] PAL_F  = CNT_W'(PAL_FIELD_LINES);

  logic               palQ, progQ;
  logic [CNT_W-1:0]   sampleCnt, lineCnt;
  logic [FIELD_W-1:0] fieldCnt;

  stdTimingT        tm;
  logic [CNT_W-1:0] fieldLines, fieldHalves, frameLines, halfIdx, fieldPos, halfPos;
  logic             secondHalf, inField2, lineEnd, frameEnd, midFieldEnd;

  always_comb begin
    tm          = stdTiming(palQ, progQ);
    fieldLines  = palQ ? PAL_F : NTSC_F;
    // 2F half lines per field non-interlaced, 2F+1 interlaced
    fieldHalves = {fieldLines[CNT_W-2:0], ~progQ};
    // interlaced frame of 2F+1 lines equals one field's half-line count
    frameLines  = progQ ? fieldLines : fieldHalves;
    secondHalf  = sampleCnt >= tm.halfLen;
    halfPos     = secondHalf ? (sampleCnt - tm.halfLen) : sampleCnt;
    halfIdx     = {lineCnt[CNT_W-2:0], secondHalf};
    inField2    = !progQ && (halfIdx >= fieldHalves);
    fieldPos    = inField2 ? (halfIdx - fieldHalves) : halfIdx;
    lineEnd     = sampleCnt == (tm.lineLen - 1'b1);
    frameEnd    = lineEnd && (lineCnt == (frameLines - 1'b1));
    midFieldEnd = !progQ && (lineCnt == fieldLines) && (sampleCnt == (tm.halfLen - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      lineCnt   <= '0;
      fieldCnt  <= '0;
      palQ      <= palSel;
      progQ     <= progSel;
    end else begin
      if (lineEnd) begin
        sampleCnt <= '0;
        lineCnt   <= frameEnd ? '0 : lineCnt + 1'b1;
      end else begin
        sampleCnt <= sampleCnt + 1'b1;
      end
      if (frameEnd) begin
        palQ  <= palSel;
        progQ <= progSel;
      end
      if ((frameEnd || midFieldEnd) && !progQ)
        fieldCnt <= fieldCnt + 1'b1;
    end
  end

  always_comb begin
    tick.pal         = palQ;
    tick.prog        = progQ;
    tick.sampleCnt   = sampleCnt;
    tick.halfPos     = halfPos;
    tick.fieldPos    = fieldPos;
    tick.fieldHalves = fieldHalves;
    tick.lineCnt     = lineCnt;
    tick.fieldCnt    = fieldCnt;
  end

endmodule

// File: rtl/vidSyncShape.sv
module vidSyncShape
  import vidSyncPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tickT               tick,
  output logic               hSyncN,
  output logic               vSyncN,
  output logic               blankOut,
  output logic               burstGate,
  output logic [1:0]         syncLevel,
  output logic [FIELD_W-1:0] fieldNum,
  output logic [CNT_W-1:0]   lineNum
);

  stdTimingT        tm;
  logic [CNT_W-1:0] preStart, burstEndS, supEnd, supPreStart;
  logic             inVs, inPre, inEq, vBlank, hBlank, tipNow, burstWin, suppress;
  syncLvlT          lvlNext;

  always_comb begin
    tm        = stdTiming(tick.pal, tick.prog);
    preStart  = tick.fieldHalves - tm.preHalves;
    inVs      = tick.fieldPos < tm.vsHalves;
    inPre     = tick.fieldPos >= preStart;
    inEq      = !inVs && ((tick.fieldPos < tm.postEnd) || inPre);
    vBlank    = (tick.fieldPos < tm.vbEnd) || inPre;
    hBlank    = (tick.sampleCnt < tm.hbEnd) || (tick.sampleCnt >= tm.fpStart);

    if (inVs)      tipNow = tick.halfPos < tm.broadWidth;
    else if (inEq) tipNow = tick.halfPos < tm.eqWidth;
    else           tipNow = tick.sampleCnt < tm.hsWidth;

    if (tick.pal) begin
      supEnd      = palBurstEnd(tick.fieldCnt[1:0]);
      supPreStart = tick.fieldHalves - palBurstPre(tick.fieldCnt[1:0]);
    end else begin
      supEnd      = NTSC_BURST_END;
      supPreStart = preStart;
    end
    suppress  = (tick.fieldPos < supEnd) || (tick.fieldPos >= supPreStart);
    burstEndS = tm.burstStart + tm.burstLen;
    burstWin  = (tick.sampleCnt >= tm.burstStart) && (tick.sampleCnt < burstEndS);

    if (tipNow)                 lvlNext = LVL_TIP;
    else if (vBlank || hBlank)  lvlNext = LVL_BLANK;
    else                        lvlNext = LVL_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hSyncN    <= 1'b1;
      vSyncN    <= 1'b1;
      blankOut  <= 1'b1;
      burstGate <= 1'b0;
      syncLevel <= LVL_BLANK;
      fieldNum  <= '0;
      lineNum   <= CNT_W'(1);
    end else begin
      hSyncN    <= !(tick.sampleCnt < tm.hsWidth);
      vSyncN    <= !inVs;
      blankOut  <= vBlank || hBlank;
      burstGate <= burstWin && !suppress;
      syncLevel <= lvlNext;
      fieldNum  <= tick.fieldCnt;
      lineNum   <= tick.lineCnt + 1'b1;
    end
  end

endmodule

// File: rtl/vidSyncGen.sv
module vidSyncGen
  import vidSyncPkg::*;
#(
  parameter int NTSC_FIELD_LINES = 262,
  parameter int PAL_FIELD_LINES  = 312
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        palSel,
  input  logic        progSel,
  output logic        hSyncN,
  output logic        vSyncN,
  output logic        blankOut,
  output logic        burstGate,
  output logic [1:0]  syncLevel,
  output logic [2:0]  fieldNum,
  output logic [10:0] lineNum
);

  tickT tick;

  vidSyncCtrl #(
    .NTSC_FIELD_LINES(NTSC_FIELD_LINES),
    .PAL_FIELD_LINES (PAL_FIELD_LINES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .palSel (palSel),
    .progSel(progSel),
    .tick   (tick)
  );

  vidSyncShape shape_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .hSyncN   (hSyncN),
    .vSyncN   (vSyncN),
    .blankOut (blankOut),
    .burstGate(burstGate),
    .syncLevel(syncLevel),
    .fieldNum (fieldNum),
    .lineNum  (lineNum)
  );

endmodule

// File: rtl/vidSyncGenChk.sv
module vidSyncGenChk (
  input logic        clk,
  input logic        rstN,
  input logic        palSel,
  input logic        progSel,
  input logic        hSyncN,
  input logic        vSyncN,
  input logic        blankOut,
  input logic        burstGate,
  input logic [1:0]  syncLevel,
  input logic [2:0]  fieldNum,
  input logic [10:0] lineNum
);

  logic [6:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)        lowRun <= '0;
    else if (!hSyncN) lowRun <= lowRun + 1'b1;
    else              lowRun <= '0;
  end

  // R2
  hsync_width_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hSyncN |-> (lowRun < 7'd63));

  // R2
  hsync_width_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hSyncN) |-> (lowRun == 7'd63));

  // R3
  level_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncLevel != 2'd3);

  // R3
  tip_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncLevel == 2'd0) |-> blankOut);

  // R3
  active_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncLevel == 2'd2) |-> (!blankOut && hSyncN && vSyncN));

  // R4
  burst_in_hblank_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstGate |-> (blankOut && hSyncN && (syncLevel == 2'd1)));

  // R6
  vsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vSyncN |-> blankOut);

  // R1
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineNum) |-> $fell(hSyncN));

  // R9
  field_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldNum) |-> $fell(vSyncN));

endmodule

bind vidSyncGen vidSyncGenChk chk_i (.*);

// File: tb/vidSyncGen_tb_top.sv
module vidSyncGen_tb_top;

  localparam int NF = 30;
  localparam int PF = 36;
  localparam int NL = 858;
  localparam int PL = 864;
  localparam int B1 = (2*NF+1)*NL;
  localparam int B2 = B1 + (2*PF+1)*PL;
  localparam int B3 = B2 + NF*NL;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        palSel = 1'b0;
  logic        progSel = 1'b0;
  logic        hSyncN, vSyncN, blankOut, burstGate;
  logic [1:0]  syncLevel;
  logic [2:0]  fieldNum;
  logic [10:0] lineNum;

  int idx = -1;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vidSyncGen #(.NTSC_FIELD_LINES(NF), .PAL_FIELD_LINES(PF)) dut_i (.*);

  always @(posedge clk) if (rstN) idx <= idx + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic at(input int base, input int len, input int line, input int s);
    while (idx < base + line*len + s) @(negedge clk);
  endtask

  task automatic testReset;
    repeat (4) @(negedge clk);
    chk("R11", "hSyncN in reset", hSyncN, 1);
    chk("R11", "vSyncN in reset", vSyncN, 1);
    chk("R11", "blank in reset", blankOut, 1);
    chk("R11", "burst in reset", burstGate, 0);
    chk("R11", "level in reset", syncLevel, 1);
    chk("R11", "field in reset", fieldNum, 0);
    chk("R11", "line in reset", lineNum, 1);
    rstN = 1'b1;
  endtask

  task automatic testNtscVert;
    at(0, NL, 0, 0);
    chk("R11", "first sample hSyncN", hSyncN, 0);
    chk("R5", "vsync half 0", vSyncN, 0);
    chk("R5", "broad tip start", syncLevel, 0);
    chk("R1", "line number 1", lineNum, 1);
    at(0, NL, 0, 364); chk("R5", "broad tip last", syncLevel, 0);
    at(0, NL, 0, 365); chk("R5", "after broad", syncLevel, 1);
    chk("R5", "vsync held", vSyncN, 0);
    at(0, NL, 0, 793); chk("R5", "broad 2nd half last", syncLevel, 0);
    at(0, NL, 0, 794); chk("R5", "broad 2nd half end", syncLevel, 1);
    at(0, NL, 3, 30);  chk("R5", "post eq tip", syncLevel, 0);
    chk("R5", "vsync over", vSyncN, 1);
    at(0, NL, 3, 31);  chk("R5", "post eq end", syncLevel, 1);
    chk("R2", "hsync still low", hSyncN, 0);
    at(0, NL, 3, 459); chk("R5", "post eq 2nd tip", syncLevel, 0);
    at(0, NL, 3, 460); chk("R5", "post eq 2nd end", syncLevel, 1);
  endtask

  task automatic testNtscHoriz;
    at(0, NL, 5, 71);  chk("R8", "burst off half 10", burstGate, 0);
    at(0, NL, 6, 62);  chk("R2", "hsync last low", hSyncN, 0);
    chk("R5", "normal tip", syncLevel, 0);
    at(0, NL, 6, 63);  chk("R2", "hsync high", hSyncN, 1);
    chk("R5", "after hsync", syncLevel, 1);
    at(0, NL, 6, 70);  chk("R4", "burst before", burstGate, 0);
    at(0, NL, 6, 71);  chk("R4", "burst first", burstGate, 1);
    at(0, NL, 6, 101); chk("R4", "burst last", burstGate, 1);
    at(0, NL, 6, 102); chk("R4", "burst after", burstGate, 0);
    at(0, NL, 6, 429); chk("R5", "no tip 2nd half", syncLevel, 1);
    at(0, NL, 16, 400); chk("R6", "vblank last line", blankOut, 1);
    at(0, NL, 17, 126); chk("R3", "hblank end-1", blankOut, 1);
    at(0, NL, 17, 127); chk("R3", "active start", syncLevel, 2);
    chk("R3", "blank low", blankOut, 0);
    chk("R1", "line number 18", lineNum, 18);
    at(0, NL, 17, 837); chk("R3", "active last", syncLevel, 2);
    at(0, NL, 17, 838); chk("R3", "front porch", syncLevel, 1);
  endtask

  task automatic testNtscFieldEdge;
    at(0, NL, 27, 71);  chk("R8", "burst before pre eq", burstGate, 1);
    at(0, NL, 27, 200); chk("R6", "active before pre eq", syncLevel, 2);
    at(0, NL, 27, 429); chk("R5", "pre eq tip", syncLevel, 0);
    at(0, NL, 27, 460); chk("R5", "pre eq end", syncLevel, 1);
    at(0, NL, 28, 71);  chk("R8", "burst off pre eq", burstGate, 0);
    at(0, NL, 30, 0);   chk("R7", "field1 tail eq tip", syncLevel, 0);
    chk("R7", "no vsync yet", vSyncN, 1);
    chk("R9", "field 0", fieldNum, 0);
    at(0, NL, 30, 31);  chk("R7", "field1 tail eq end", syncLevel, 1);
    at(0, NL, 30, 429); chk("R7", "field2 vsync mid line", vSyncN, 0);
    chk("R9", "field 1", fieldNum, 1);
    chk("R7", "field2 broad tip", syncLevel, 0);
    at(0, NL, 30, 793); chk("R7", "field2 broad last", syncLevel, 0);
    at(0, NL, 30, 794); chk("R7", "field2 broad end", syncLevel, 1);
    at(0, NL, 36, 71);  chk("R8", "field2 burst off", burstGate, 0);
    at(0, NL, 37, 71);  chk("R8", "field2 burst on", burstGate, 1);
  endtask

  task automatic testModeHold1;
    at(0, NL, 38, 0);
    palSel = 1'b1;
    at(0, NL, 40, 840); chk("R10", "525 porch kept", blankOut, 1);
    at(0, NL, 60, 857); chk("R1", "last line", lineNum, 61);
  endtask

  task automatic testPal;
    at(B1, PL, 0, 0);   chk("R9", "field 2", fieldNum, 2);
    chk("R10", "625 vsync", vSyncN, 0);
    at(B1, PL, 0, 368); chk("R5", "625 broad last", syncLevel, 0);
    at(B1, PL, 0, 369); chk("R5", "625 broad end", syncLevel, 1);
    at(B1, PL, 2, 463); chk("R5", "625 eq tip", syncLevel, 0);
    at(B1, PL, 2, 464); chk("R5", "625 eq end", syncLevel, 1);
    at(B1, PL, 4, 75);  chk("R8", "seq2 burst off", burstGate, 0);
    at(B1, PL, 5, 75);  chk("R8", "seq2 burst on", burstGate, 1);
    at(B1, PL, 22, 200); chk("R6", "625 vblank", blankOut, 1);
    at(B1, PL, 23, 200); chk("R6", "625 after vblank", syncLevel, 2);
    at(B1, PL, 30, 74);  chk("R4", "625 burst before", burstGate, 0);
    at(B1, PL, 30, 75);  chk("R4", "625 burst first", burstGate, 1);
    at(B1, PL, 30, 105); chk("R4", "625 burst last", burstGate, 1);
    at(B1, PL, 30, 106); chk("R4", "625 burst after", burstGate, 0);
    at(B1, PL, 30, 141); chk("R3", "625 hblank", syncLevel, 1);
    at(B1, PL, 30, 142); chk("R3", "625 active", syncLevel, 2);
    chk("R1", "625 line number", lineNum, 31);
    at(B1, PL, 30, 843); chk("R1", "625 active last", syncLevel, 2);
    at(B1, PL, 30, 844); chk("R3", "625 porch", blankOut, 1);
    at(B1, PL, 36, 432); chk("R9", "field 3", fieldNum, 3);
    at(B1, PL, 42, 75);  chk("R8", "seq3 burst off", burstGate, 0);
    at(B1, PL, 43, 75);  chk("R8", "seq3 burst on", burstGate, 1);
  endtask

  task automatic testModeHold2;
    at(B1, PL, 50, 0);
    palSel  = 1'b0;
    progSel = 1'b1;
    at(B1, PL, 60, 842); chk("R10", "625 active kept", syncLevel, 2);
  endtask

  task automatic testProg;
    at(B2, NL, 0, 0);    chk("R9", "field 4", fieldNum, 4);
    chk("R7", "prog vsync", vSyncN, 0);
    at(B2, NL, 4, 459);  chk("R5", "prog post eq tip", syncLevel, 0);
    at(B2, NL, 5, 459);  chk("R5", "prog no eq", syncLevel, 1);
    at(B2, NL, 27, 429); chk("R5", "prog no tip", syncLevel, 2);
    at(B2, NL, 28, 30);  chk("R5", "prog pre eq tip", syncLevel, 0);
    at(B2, NL, 28, 31);  chk("R5", "prog pre eq end", syncLevel, 1);
    at(B2, NL, 28, 200); chk("R6", "prog vblank", blankOut, 1);
    at(B2, NL, 29, 857); chk("R7", "prog last line", lineNum, 30);
    at(B3, NL, 0, 10);   chk("R7", "prog next field", vSyncN, 0);
    chk("R9", "prog field held", fieldNum, 4);
    chk("R7", "prog line 1", lineNum, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", idx, B3);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testNtscVert();
    testNtscHoriz();
    testNtscFieldEdge();
    testModeHold1();
    testPal();
    testModeHold2();
    testProg();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule